// File: doc/BRIEF.md
# Source-Synchronous DDR Frame Deserializer

This block is the receive end of a four-lane, source-synchronous link. The transmitter sends a forwarded bit clock and a frame clock together with four serial data lanes. Every lane carries one 12-bit word per frame, and bits change on both edges of the bit clock, so a frame lasts six bit-clock periods. The block takes two samples from every lane in each bit-clock period, one on each edge. It also samples the frame clock in the same way, so the frame clock can serve as a marker for where each word starts. When the marker shows that a word is complete, the block presents all four words in parallel together with a single-cycle valid strobe.

An alignment monitor runs beside the data path. During link bring-up the transmitter sends one of two fixed words on every lane. For each lane, the monitor reports whether that lane has delivered the expected word for several frames in a row. Firmware uses these flags, together with an aligned status, to confirm that its clock-phase or bit-slip calibration has worked. The converted words can be read in offset binary or in two's complement. The format is chosen by a mode input.

Top module: `ddr_frame_deser`

## Requirements
- R1: While `rst_n` is sampled low on a rising `dco` edge, the block clears its shift registers, boundary pointer, match counters and flags. From the next cycle on, `word_valid`, `aligned` and `pat_match` read 0 and every word of `word_out` reads 0 (with `tc_en` low).
- R2: In each `dco` period, the half-bit sampled on the rising edge comes before the one sampled on the following falling edge. Words are assembled MSB first, so the first half-bit of a word becomes bit 11.
- R3: The frame clock is sampled like a data lane. A 0 followed by a 1 in two consecutive half-bit samples marks the 1 as the first bit of a new word. The boundary may fall on either the rising-edge sample or the falling-edge sample, and the word presented is the 12 half-bits just before that first bit.
- R4: `word_valid` is high for exactly one cycle per accepted boundary, and all four lanes update together. The first boundary after reset produces no strobe, because the word before it is incomplete.
- R5: A boundary is accepted only when it falls on the same sample position as the previous boundary. An accepted boundary sets `aligned`. A boundary at the other position clears `aligned`, moves the pointer and suppresses `word_valid` for that frame. The next boundary at the new position is accepted again.
- R6: `pat_sel` = 0 expects 0x800 and `pat_sel` = 1 expects 0xAAA. A lane's `pat_match` bit rises one cycle after the strobe of the 4th consecutive valid word equal to the expected word. Any valid word that differs clears the bit. Frames without a strobe leave the count unchanged.
- R7: With `tc_en` = 1, bit 11 of every word on `word_out` is inverted (offset binary to two's complement). Pattern matching always uses the unconverted word.
- R8: Lanes are independent: lane n occupies `word_out[12n+11:12n]` and `lane_in[n]`, and a mismatch on one lane does not affect another lane's `pat_match` bit.
- R9: Between strobes, `word_out` holds the last accepted words as long as `tc_en` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco | input | 1 | Forwarded bit clock; data is sampled on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| fco | input | 1 | Forwarded frame clock, sampled as a half-bit stream |
| lane_in | input | 4 | Serial data lanes, one bit per lane |
| pat_sel | input | 1 | Expected calibration word: 0 selects 0x800, 1 selects 0xAAA |
| tc_en | input | 1 | 1 inverts the MSB of each output word |
| word_out | output | 48 | Four parallel words, lane n at bits 12n+11..12n |
| word_valid | output | 1 | One-cycle strobe for a new set of words |
| pat_match | output | 4 | Per-lane flag: the calibration word has been seen on 4 frames in a row |
| aligned | output | 1 | The last boundary matched the stored pointer |

## Verification
The bench goes after the two boundary positions and the switch between them. A design that tied the boundary to one edge, or that accepted the first word after reset, would present shifted or partial words and strobe one frame too often. An injected half-bit slip must drop `aligned` and hide exactly one strobe; a design that ignored the moved pointer would deliver a word 13 half-bits long. The match counter is tested at three, four and a broken run, with the select changed between runs; an off-by-one counter or a flag shared across lanes shows up as a wrong `pat_match` bit. The MSB inversion is also checked for any leak into the pattern comparison.

// File: rtl/ddr_deser_pkg.sv
// Shared types and helpers for the DDR frame deserializer.
// Assumes word widths of at least two bits.
package ddr_deser_pkg;

    // Which half of a bit-clock period carried the first bit of a word.
    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } half_phase_e;

    // Bit idx of a calibration word: alt=0 gives MSB-only, alt=1 gives
    // alternating ones starting at the MSB.
    function automatic logic pattern_bit(input logic alt, input int idx, input int width);
        if (alt) begin
            return ((width - 1 - idx) % 2) == 0;
        end
        return idx == (width - 1);
    endfunction

endpackage

// File: rtl/ddr_half_capture.sv
// Dual-edge input sampler: one register bank on each bit-clock edge.
// Assumes inputs are settled around both edges (no delay tuning here).
module ddr_half_capture #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q
);

    // Rising-edge half-bit sample.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= din;
    end

    // Falling-edge half-bit sample.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din;
    end

endmodule

// File: rtl/frame_aligner.sv
// Takes one half-bit pair per lane per bit-clock cycle (rise sample
// first), finds word starts from the sampled frame clock, and emits all
// lanes' words with a shared strobe when the boundary position is steady.
// Assumes WORD_W is even so that a frame spans whole bit-clock cycles.
module frame_aligner
    import ddr_deser_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fco_a,
    input  logic                      fco_b,
    input  logic [LANES-1:0]          lane_a,
    input  logic [LANES-1:0]          lane_b,
    output logic [LANES*WORD_W-1:0]   word_flat,
    output logic                      word_valid,
    output logic                      aligned
);

    logic        fco_last;
    half_phase_e ptr;
    logic        have_ptr;
    logic        bnd_rise, bnd_fall, bnd;
    half_phase_e ph;
    logic        accept;

    // Boundary detection across the previous and current half-bit samples.
    always_comb begin
        bnd_rise = !fco_last && fco_a;
        bnd_fall = !fco_a && fco_b;
        bnd      = bnd_rise || bnd_fall;
        ph       = bnd_rise ? PH_RISE : PH_FALL;
        accept   = bnd && have_ptr && (ph == ptr);
    end

    // Pointer, aligned status and strobe bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fco_last   <= 1'b0;
            ptr        <= PH_RISE;
            have_ptr   <= 1'b0;
            aligned    <= 1'b0;
            word_valid <= 1'b0;
        end else begin
            fco_last   <= fco_b;
            word_valid <= accept;
            if (bnd) begin
                ptr      <= ph;
                have_ptr <= 1'b1;
                aligned  <= accept;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WORD_W-1:0]   sreg;
        logic [WORD_W+1:0]   nxt;
        logic [WORD_W-1:0]   word_q;

        assign nxt = {sreg, lane_a[l], lane_b[l]};

        // Shift two half-bits per cycle; latch the word ending before the boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sreg   <= '0;
                word_q <= '0;
            end else begin
                sreg <= nxt[WORD_W-1:0];
                if (accept) begin
                    word_q <= (ph == PH_FALL) ? nxt[WORD_W:1] : nxt[WORD_W+1:2];
                end
            end
        end

        assign word_flat[l*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/pattern_matcher.sv
// Per-lane calibration monitor: counts consecutive strobed words equal to
// the expected word and raises a flag once the run reaches MATCH_FRAMES.
// Assumes MATCH_FRAMES >= 1.
module pattern_matcher #(
    parameter int WORD_W       = 12,
    parameter int MATCH_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] expected,
    output logic              match
);

    localparam int CNT_W = $clog2(MATCH_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MATCH_FRAMES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MATCH_FRAMES - 1);

    logic [CNT_W-1:0] run_cnt;

    // Update the run length and flag on each strobed word only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            match   <= 1'b0;
        end else if (valid) begin
            if (word == expected) begin
                if (run_cnt != CNT_TOP) run_cnt <= run_cnt + 1'b1;
                match <= (run_cnt >= CNT_LAST);
            end else begin
                run_cnt <= '0;
                match   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ddr_frame_deser.sv
// Top of the four-lane DDR frame deserializer. Samples frame clock and
// lanes on both bit-clock edges, aligns words to the frame marker, checks
// the calibration pattern per lane and optionally flips word MSBs.
// Assumes dco is the only clock and rst_n is synchronous to it.
module ddr_frame_deser
    import ddr_deser_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int WORD_W       = 12,
    parameter int MATCH_FRAMES = 4
) (
    input  logic                      dco,
    input  logic                      rst_n,
    input  logic                      fco,
    input  logic [LANES-1:0]          lane_in,
    input  logic                      pat_sel,
    input  logic                      tc_en,
    output logic [LANES*WORD_W-1:0]   word_out,
    output logic                      word_valid,
    output logic [LANES-1:0]          pat_match,
    output logic                      aligned
);

    localparam int CAP_W = LANES + 1;

    logic [CAP_W-1:0]        rise_q, fall_q;
    logic [LANES*WORD_W-1:0] raw_words;
    logic [WORD_W-1:0]       expected;

    ddr_half_capture #(.WIDTH(CAP_W)) u_cap (
        .clk    (dco),
        .rst_n  (rst_n),
        .din    ({fco, lane_in}),
        .rise_q (rise_q),
        .fall_q (fall_q)
    );

    frame_aligner #(.LANES(LANES), .WORD_W(WORD_W)) u_align (
        .clk        (dco),
        .rst_n      (rst_n),
        .fco_a      (rise_q[LANES]),
        .fco_b      (fall_q[LANES]),
        .lane_a     (rise_q[LANES-1:0]),
        .lane_b     (fall_q[LANES-1:0]),
        .word_flat  (raw_words),
        .word_valid (word_valid),
        .aligned    (aligned)
    );

    // Expected calibration word, built bit by bit from the select.
    for (genvar i = 0; i < WORD_W; i++) begin : g_exp
        assign expected[i] = pattern_bit(pat_sel, i, WORD_W);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pattern_matcher #(.WORD_W(WORD_W), .MATCH_FRAMES(MATCH_FRAMES)) u_match (
            .clk      (dco),
            .rst_n    (rst_n),
            .valid    (word_valid),
            .word     (raw_words[l*WORD_W +: WORD_W]),
            .expected (expected),
            .match    (pat_match[l])
        );
        assign word_out[l*WORD_W +: WORD_W] =
            raw_words[l*WORD_W +: WORD_W] ^ {tc_en, {(WORD_W-1){1'b0}}};
    end

endmodule

// File: rtl/ddr_frame_deser_checker.sv
// Temporal properties of the deserializer's ports, bound to every instance.
module ddr_frame_deser_checker #(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input logic                    dco,
    input logic                    rst_n,
    input logic                    tc_en,
    input logic [LANES*WORD_W-1:0] word_out,
    input logic                    word_valid,
    input logic [LANES-1:0]        pat_match,
    input logic                    aligned
);

    assert_reset_clear_R1: assert property (@(posedge dco)
        !rst_n |=> (!word_valid && !aligned && pat_match == '0));

    assert_valid_single_R4: assert property (@(posedge dco) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_valid_aligned_R5: assert property (@(posedge dco) disable iff (!rst_n)
        word_valid |-> aligned);

    assert_match_rise_R6: assert property (@(posedge dco) disable iff (!rst_n)
        ((pat_match & ~$past(pat_match)) != '0) |-> $past(word_valid));

    assert_match_hold_R6: assert property (@(posedge dco) disable iff (!rst_n)
        !$past(word_valid) |-> $stable(pat_match));

    assert_word_hold_R9: assert property (@(posedge dco) disable iff (!rst_n)
        (!word_valid && $stable(tc_en)) |-> $stable(word_out));

endmodule

bind ddr_frame_deser ddr_frame_deser_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .dco        (dco),
    .rst_n      (rst_n),
    .tc_en      (tc_en),
    .word_out   (word_out),
    .word_valid (word_valid),
    .pat_match  (pat_match),
    .aligned    (aligned)
);

// File: tb/tb_ddr_frame_deser.sv
module tb_ddr_frame_deser;

    logic        dco = 1'b0;
    logic        rst_n = 1'b0;
    logic        fco = 1'b0;
    logic [3:0]  lane_in = '0;
    logic        pat_sel = 1'b0;
    logic        tc_en = 1'b0;
    logic [47:0] word_out;
    logic        word_valid;
    logic [3:0]  pat_match;
    logic        aligned;

    ddr_frame_deser dut (
        .dco(dco), .rst_n(rst_n), .fco(fco), .lane_in(lane_in),
        .pat_sel(pat_sel), .tc_en(tc_en), .word_out(word_out),
        .word_valid(word_valid), .pat_match(pat_match), .aligned(aligned)
    );

    always #4 dco = ~dco;   // 125 MHz

    int tests = 0, fails = 0, vcnt = 0;
    bit started = 0, done = 0;
    logic [9:0] sent_q[$];
    bit half = 0;
    logic pend_f;
    logic [3:0] pend_l;

    // Reference model state
    bit          mq[4][$];
    logic        m_fl, m_ptr, m_have, m_al, m_val;
    logic [11:0] m_w[4];
    int          m_cnt[4];
    logic [3:0]  m_match;

    function automatic logic [11:0] exp_pat(input logic sel);
        return sel ? 12'hAAA : 12'h800;
    endfunction

    function automatic logic [11:0] qword(input int l, input int off);
        logic [11:0] r = '0;
        for (int j = 0; j < 12; j++) r = {r[10:0], mq[l][j+off]};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_pair(input logic f0, input logic [3:0] l0, input logic f1, input logic [3:0] l1);
        @(negedge dco); #2; fco = f0; lane_in = l0;
        @(posedge dco); #2; fco = f1; lane_in = l1;
        sent_q.push_back({f0, f1, l0, l1});
    endtask

    task automatic emit(input logic f, input logic [3:0] l);
        if (!half) begin
            pend_f = f; pend_l = l; half = 1;
        end else begin
            half = 0;
            send_pair(pend_f, pend_l, f, l);
        end
    endtask

    task automatic send_frame(input logic [11:0] w0, input logic [11:0] w1,
                              input logic [11:0] w2, input logic [11:0] w3);
        for (int i = 0; i < 12; i++)
            emit(i < 6, {w3[11-i], w2[11-i], w1[11-i], w0[11-i]});
    endtask

    task automatic send_same(input logic [11:0] w, input int n);
        for (int k = 0; k < n; k++) send_frame(w, w, w, w);
    endtask

    // Behavioural model: consumes one half-bit pair per cycle, one cycle late.
    always @(posedge dco) begin
        logic [9:0] p;
        logic a_f, b_f;
        logic [3:0] a_l, b_l;
        bit bnd, ph;
        #1;
        p = '0;
        if (sent_q.size() > 0) p = sent_q.pop_front();
        {a_f, b_f, a_l, b_l} = p;
        if (!rst_n) begin
            started = 1;
            m_fl = 0; m_ptr = 0; m_have = 0; m_al = 0; m_val = 0; m_match = '0;
            for (int l = 0; l < 4; l++) begin
                mq[l].delete();
                for (int j = 0; j < 14; j++) mq[l].push_back(1'b0);
                m_w[l] = '0; m_cnt[l] = 0;
            end
        end else begin
            if (m_val) begin
                for (int l = 0; l < 4; l++) begin
                    if (m_w[l] == exp_pat(pat_sel)) begin
                        if (m_cnt[l] < 4) m_cnt[l]++;
                    end else m_cnt[l] = 0;
                    m_match[l] = (m_cnt[l] >= 4);
                end
            end
            for (int l = 0; l < 4; l++) begin
                mq[l].push_back(a_l[l]);
                mq[l].push_back(b_l[l]);
                while (mq[l].size() > 14) void'(mq[l].pop_front());
            end
            bnd = 0; ph = 0;
            if (!m_fl && a_f) bnd = 1;
            else if (!a_f && b_f) begin bnd = 1; ph = 1; end
            m_fl = b_f;
            m_val = 0;
            if (bnd) begin
                if (m_have && ph == m_ptr) begin
                    m_val = 1; m_al = 1;
                    for (int l = 0; l < 4; l++) m_w[l] = qword(l, ph ? 1 : 0);
                end else m_al = 0;
                m_ptr = ph; m_have = 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(posedge dco) begin
        logic [47:0] ew;
        #3;
        if (started && !done) begin
            for (int l = 0; l < 4; l++) ew[l*12 +: 12] = m_w[l] ^ (tc_en ? 12'h800 : 12'h000);
            chk("R4 word_valid", {47'b0, word_valid}, {47'b0, m_val});
            chk("R5 aligned", {47'b0, aligned}, {47'b0, m_al});
            chk("R6 pat_match", {44'b0, pat_match}, {44'b0, m_match});
            chk("R3 word_out", word_out, ew);
            if (word_valid) vcnt++;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge dco);
        @(negedge dco); #1 rst_n = 1;
        @(posedge dco); #3;
        chk("R1 valid after reset", {47'b0, word_valid}, 48'd0);
        chk("R1 aligned after reset", {47'b0, aligned}, 48'd0);
        chk("R1 match after reset", {44'b0, pat_match}, 48'd0);
        chk("R1 words after reset", word_out, 48'd0);

        // R3/R4: steady frames, rising-edge boundary
        vcnt = 0;
        for (int f = 0; f < 8; f++)
            send_frame(12'((f * 1103 + 17) & 12'hFFF), 12'((f * 389 + 5) & 12'hFFF),
                       12'((f * 2711 + 99) & 12'hFFF), 12'((f * 77 + 3000) & 12'hFFF));
        chk("R4 strobes for 8 frames", 48'(vcnt), 48'd7);
        chk("R5 aligned steady", {47'b0, aligned}, 48'd1);

        // R2/R8/R9: MSB-first order, distinct lanes, hold between strobes
        send_frame(12'hC01, 12'h003, 12'h7FE, 12'h5A5);
        send_frame(12'h111, 12'h222, 12'h333, 12'h444);
        chk("R2 lane0 msb first", {36'b0, word_out[11:0]}, 48'hC01);
        chk("R8 lane words", word_out, {12'h5A5, 12'h7FE, 12'h003, 12'hC01});
        chk("R9 held until next strobe", {47'b0, word_valid}, 48'd0);

        // R6: pattern 0x800
        pat_sel = 0;
        send_same(12'h800, 4);
        chk("R6 no match after 3", {44'b0, pat_match}, 48'd0);
        send_same(12'h800, 1);
        chk("R6 match after 4", {44'b0, pat_match}, 48'hF);

        // R8: mismatch on lane 2 only
        send_frame(12'h800, 12'h800, 12'h801, 12'h800);
        send_frame(12'h800, 12'h800, 12'h800, 12'h800);
        chk("R8 lane2 cleared only", {44'b0, pat_match}, 48'hB);

        // R6: pattern 0xAAA
        pat_sel = 1;
        send_same(12'hAAA, 5);
        chk("R6 match pattern 0xAAA", {44'b0, pat_match}, 48'hF);

        // R7: MSB inversion, matching unaffected
        tc_en = 1;
        send_same(12'hAAA, 2);
        chk("R7 msb inverted", {36'b0, word_out[11:0]}, 48'h2AA);
        chk("R7 match unaffected", {44'b0, pat_match}, 48'hF);
        tc_en = 0;

        // R5/R3: half-bit slip moves boundary to falling-edge sample
        emit(1'b0, 4'h0);
        vcnt = 0;
        send_same(12'hAAA, 1);
        chk("R5 aligned dropped on slip", {47'b0, aligned}, 48'd0);
        chk("R5 strobe suppressed on slip", 48'(vcnt), 48'd0);
        send_frame(12'h9C3, 12'h0F0, 12'hAAA, 12'h123);
        send_same(12'hAAA, 1);
        chk("R5 relocked", {47'b0, aligned}, 48'd1);
        chk("R5 strobes after relock", 48'(vcnt), 48'd2);
        chk("R3 falling-phase word", word_out, {12'h123, 12'hAAA, 12'h0F0, 12'h9C3});

        send_same(12'h000, 2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule